// File: doc/BRIEF.md
# Sample Pacing Divider with Elapsed-Time Limit

This block paces a multi-channel capture engine. It runs on a fixed internal timebase (100 MHz in the normal mode) and emits a one-cycle sample-enable strobe at a programmable fraction of that rate. The host writes a divider maximum of (100 MHz / requested rate) - 1. For the fastest rate the clock is boosted to 125 MHz and the divider is skipped, so a sample is taken on every cycle. When the capture engine runs from an external sample clock, the divider is also skipped.

Alongside the pacer, the block keeps an elapsed-time counter that the host reads back. A prescaler counts a fixed number of clock cycles per unit, which is one millisecond at 100 MHz. The prescaler does not change when the divider is bypassed, so in the 125 MHz boost mode one unit is 0.8 ms and the host corrects for that. When the elapsed count reaches the host's limit, the block ends the capture and raises a stop request. The stop request stays high until the next capture start.

Top module: `sample_pacer`

## Requirements
- R1: After reset, `sample_en`, `stop_req` and `running` are 0 and `elapsed` is 0.
- R2: When not bypassed and `div_max` = D > 0, `sample_en` is a one-cycle pulse every D+1 clocks. The first pulse comes D+1 clocks after the capture-start cycle.
- R3: With `bypass` = 1, `sample_en` is high on every clock from the cycle after capture start while running, whatever the value of `div_max`.
- R4: With `ext_clk_sel` = 1 and `bypass` = 0, `sample_en` behaves exactly as in R3.
- R5: A `div_max` of 0 gives a sample on every clock, the same as bypass.
- R6: `elapsed` advances by exactly one every TICK_CYCLES clocks while running. It reads k from TICK_CYCLES*k+1 clocks after the start cycle. The rate is the same in bypass and in divided mode.
- R7: When `elapsed` >= `dur_limit` while running, the following cycle shows `stop_req` = 1 and `running` = 0. From then on `elapsed` holds its value and `sample_en` stays 0.
- R8: A `cap_start` pulse clears `elapsed`, `stop_req` and the divider phase, and sets `running` from the next cycle.
- R9: While not running, `elapsed` does not change and `sample_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_start | input | 1 | One-cycle capture start pulse |
| bypass | input | 1 | Skip the divider (boost rate) |
| ext_clk_sel | input | 1 | External sample clock in use; forces bypass |
| div_max | input | DIV_W | Divider maximum, (base rate / sample rate) - 1 |
| dur_limit | input | DUR_W | Elapsed-time limit in ticks |
| sample_en | output | 1 | Registered sample-enable strobe |
| elapsed | output | DUR_W | Elapsed ticks since capture start |
| running | output | 1 | Capture in progress |
| stop_req | output | 1 | Limit reached; held until next start |

## Verification
A divider count that runs away or misses its reload shows up at `sample_en` within one divider period, as a strobe spacing other than D+1. A prescaler fault moves the step of `elapsed` away from its exact cycle one tick period after start. A fault that scales the prescaler by the bypass setting gives different `elapsed` values at the same cycle count in the two modes. A wrong run or stop state shows on the cycle after the limit is reached, or later as `elapsed` or `sample_en` moving while idle.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [0:0] {
    PACE_DIVIDED = 1'b0,
    PACE_EVERY   = 1'b1
  } pace_mode_e;
endpackage

// File: rtl/pacer_divider.sv
module pacer_divider
  import pacer_pkg::*;
#(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  pace_mode_e       mode,
  input  logic [DIV_W-1:0] div_max,
  output logic             sample_en
);
  logic [DIV_W-1:0] cnt_q;
  logic             en_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (!run) begin
      en_q <= 1'b0;
    end else if (mode == PACE_EVERY) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
    end else if (cnt_q >= div_max) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      en_q  <= 1'b0;
    end
  end

  assign sample_en = en_q;

  // R2: in divided mode with a nonzero maximum a strobe never repeats back to back
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (en_q && run && mode == PACE_DIVIDED && div_max != '0) |=> !en_q);

  // R3: every-cycle mode keeps the strobe high
  a_r3_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && mode == PACE_EVERY) |=> en_q);
endmodule

// File: rtl/pacer_tick.sv
module pacer_tick #(
  parameter int TICK_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else if (run) begin
      if (pre_q == LAST) begin
        pre_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R6: prescaler stays within one tick period
  a_r6_prescale_range: assert property (@(posedge clk) disable iff (rst)
    pre_q <= LAST);
endmodule

// File: rtl/pacer_elapsed.sv
module pacer_elapsed #(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  output logic [DUR_W-1:0] count
);
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (run && tick && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

  // R6: the count moves by at most one per cycle unless cleared
  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer
  import pacer_pkg::*;
#(
  parameter int DIV_W       = 32,
  parameter int DUR_W       = 32,
  parameter int TICK_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_start,
  input  logic             bypass,
  input  logic             ext_clk_sel,
  input  logic [DIV_W-1:0] div_max,
  input  logic [DUR_W-1:0] dur_limit,
  output logic             sample_en,
  output logic [DUR_W-1:0] elapsed,
  output logic             running,
  output logic             stop_req
);
  logic       run_q;
  logic       stop_q;
  logic       tick;
  pace_mode_e mode;

  assign mode = (bypass || ext_clk_sel || div_max == '0) ? PACE_EVERY : PACE_DIVIDED;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (cap_start) begin
      run_q  <= 1'b1;
      stop_q <= 1'b0;
    end else if (run_q && (elapsed >= dur_limit)) begin
      run_q  <= 1'b0;
      stop_q <= 1'b1;
    end
  end

  pacer_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(cap_start), .run(run_q),
    .mode(mode), .div_max(div_max), .sample_en(sample_en)
  );

  pacer_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .clr(cap_start), .run(run_q), .tick(tick)
  );

  pacer_elapsed #(.DUR_W(DUR_W)) u_elapsed (
    .clk(clk), .rst(rst), .clr(cap_start), .run(run_q),
    .tick(tick), .count(elapsed)
  );

  assign running  = run_q;
  assign stop_req = stop_q;

  // R7: reaching the limit ends the capture on the next cycle
  a_r7_limit_stops: assert property (@(posedge clk) disable iff (rst)
    (run_q && !cap_start && elapsed >= dur_limit) |=> (stop_q && !run_q));

  // R7: a stop request never coexists with a running capture
  a_r7_stop_exclusive: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> !run_q);

  // R9: idle time leaves the elapsed count untouched
  a_r9_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cap_start) |=> $stable(elapsed));
endmodule

// File: tb/sample_pacer_tb.sv
module sample_pacer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int UW = 16;
  localparam int T  = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cap_start = 1'b0;
  logic          bypass = 1'b0;
  logic          ext_clk_sel = 1'b0;
  logic [DW-1:0] div_max = '0;
  logic [UW-1:0] dur_limit = '1;
  logic          sample_en;
  logic [UW-1:0] elapsed;
  logic          running;
  logic          stop_req;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_pacer #(.DIV_W(DW), .DUR_W(UW), .TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst(rst), .cap_start(cap_start), .bypass(bypass),
    .ext_clk_sel(ext_clk_sel), .div_max(div_max), .dur_limit(dur_limit),
    .sample_en(sample_en), .elapsed(elapsed), .running(running),
    .stop_req(stop_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic start();
    @(posedge clk);
    #1 cap_start = 1'b1;
    step();
    cap_start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sample_en", sample_en, 0);
    chk("R1 stop_req", stop_req, 0);
    chk("R1 running", running, 0);
    chk("R1 elapsed", elapsed, 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 50; i++) begin
      step();
      chk("R9 idle sample_en", sample_en, 0);
      chk("R9 idle elapsed", elapsed, 0);
    end
  endtask

  task automatic t_divided(input int d);
    bypass = 1'b0; ext_clk_sel = 1'b0; div_max = DW'(d);
    start();
    chk("R8 running after start", running, 1);
    for (int i = 1; i <= 4 * (d + 1); i++) begin
      step();
      chk("R2 divided strobe", sample_en, ((i % (d + 1)) == 0) ? 1 : 0);
    end
  endtask

  task automatic t_every(input logic byp, input logic ext, input int d, input string req);
    bypass = byp; ext_clk_sel = ext; div_max = DW'(d);
    start();
    for (int i = 1; i <= 12; i++) begin
      step();
      chk(req, sample_en, 1);
    end
    bypass = 1'b0; ext_clk_sel = 1'b0;
  endtask

  task automatic t_elapsed(input logic byp, input int d);
    bypass = byp; div_max = DW'(d);
    start();
    chk("R8 elapsed cleared", elapsed, 0);
    for (int i = 1; i <= 3 * T + 1; i++) begin
      step();
      if (i == T || i == T + 1 || i == 2 * T + 1 || i == 3 * T + 1)
        chk("R6 elapsed rate", elapsed, (i - 1) / T);
    end
    bypass = 1'b0;
  endtask

  task automatic t_stop_restart();
    bypass = 1'b0; div_max = DW'(2); dur_limit = UW'(2);
    start();
    for (int i = 1; i <= 2 * T + 2; i++) begin
      step();
      if (i == 2 * T + 1) begin
        chk("R7 not yet stopped", stop_req, 0);
        chk("R7 elapsed at limit", elapsed, 2);
      end
      if (i == 2 * T + 2) begin
        chk("R7 stop_req", stop_req, 1);
        chk("R7 running low", running, 0);
      end
    end
    step();
    for (int i = 0; i < 3 * T; i++) begin
      step();
      chk("R7 elapsed held", elapsed, 2);
      chk("R7 no sampling after stop", sample_en, 0);
      chk("R9 stop held", stop_req, 1);
    end
    dur_limit = '1;
    start();
    chk("R8 restart elapsed", elapsed, 0);
    chk("R8 restart stop_req", stop_req, 0);
    chk("R8 restart running", running, 1);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_idle();
    t_divided(3);
    t_divided(6);
    t_every(1'b1, 1'b0, 5, "R3 bypass every cycle");
    t_every(1'b0, 1'b1, 5, "R4 external clock every cycle");
    t_every(1'b0, 1'b0, 0, "R5 zero maximum every cycle");
    t_elapsed(1'b1, 0);
    t_elapsed(1'b0, 4);
    t_stop_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule